// File: doc/BRIEF.md
# Lock-Bit Command Controller

This block interprets bus write cycles (a command byte plus an address) for a flash-style memory and manages its write protection. Each memory block has one lock bit, and the device has one master lock bit. A lock bit stops program and erase of its block. The master lock bit decides whether changing the block lock bits also needs a high-voltage qualifier on the reset pin. The lock bits are held in registers. The high-voltage qualifier and the programming-voltage-valid condition arrive as digital inputs. A fixed-length busy phase stands in for the internal write algorithm.

Three lock operations are available. Each is a two-write sequence: a setup byte, then a confirm byte. One confirm sets the lock bit of the block chosen by the confirm address. A second confirm sets the master lock bit and accepts any address. A third confirm clears every block lock bit at once. Protection conditions are evaluated at the confirm write. During the busy phase the ready flag stays low. At the end of that phase, either the lock state changes or a combination of error flags is posted to the status register; each failure cause has its own combination.

A separate program/erase request port is checked against the lock bit of the target block. A request to a locked block is refused with error flags. A request to an unlocked block is forwarded as a one-cycle grant.

Top module: `lockbit_cmd_ctrl`

## Requirements
- R1: After reset, status reads 0x80, all block lock bits and the master lock bit are 0, ready is 1 and rd_status_mode is 0.
- R2: Writing 0x60, then 0x01 with an address whose bits [BLK_LSB +: log2(NUM_BLK)] (bits 14:12 by default) select a block, drops ready for exactly BUSY_CYC cycles. The selected lock bit is set in the cycle ready returns, provided no protection fault applies. No other lock bit changes.
- R3: Writing 0x60, then 0xD0 (any address), clears all block lock bits together at the end of the busy phase, provided no fault applies.
- R4: Writing 0x60, then 0xF1 (any address), sets the master lock bit only if hv_qual was 1 at the confirm write. Otherwise status bits 1 and 4 are set and the master lock is unchanged. No command ever clears the master lock.
- R5: While the master lock is set, a set-block or clear sequence confirmed with hv_qual at 0 changes no lock bit. It sets status bit 1 together with bit 4 (set-block) or bit 5 (clear).
- R6: After 0x60, any confirm byte other than 0x01, 0xF1 or 0xD0 sets status bits 4 and 5 in the same cycle. In that case there is no busy phase and no lock change.
- R7: If vpp_ok is 0 at the confirm write, no lock bit changes. A clear sets status bits 3 and 5; a set-block or set-master sets bits 3 and 4. This voltage fault takes priority over the protection fault.
- R8: Writes during the busy phase are ignored. A 0x60 written while suspended is 1 sets status bits 4 and 5 and starts no sequence. A confirm written while suspended is 1 is handled as an invalid confirm.
- R9: Status error bits 5, 4, 3 and 1 stay set until a 0x50 write is accepted while ready; that write clears all four.
- R10: rd_status_mode goes to 1 on an accepted 0x60 write and returns to 0 on a 0xFF write while ready.
- R11: A pe_req to a block whose lock bit is set sets status bit 1, plus bit 4 when pe_erase is 0 or bit 5 when pe_erase is 1, on the next edge, and pe_go stays 0. A pe_req to an unlocked block while ready gives a one-cycle pe_go on the next edge and no error.
- R12: Status bit 7 always equals the ready output: 0 during the busy phase, 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_cmd | input | 8 | Command byte of the write |
| bus_addr | input | ADDR_W | Address of a write or of a program/erase request |
| pe_req | input | 1 | Program or erase request |
| pe_erase | input | 1 | 1 = request is an erase, 0 = program |
| hv_qual | input | 1 | High-voltage qualifier on the reset pin |
| vpp_ok | input | 1 | Programming voltage valid |
| suspended | input | 1 | An operation is currently suspended |
| ready | output | 1 | 0 during the busy phase (status pin) |
| status | output | 8 | Status register |
| rd_status_mode | output | 1 | Reads return status data when 1 |
| blk_locks | output | NUM_BLK | Block lock bits |
| master_lock | output | 1 | Master lock bit |
| pe_go | output | 1 | Granted program/erase request, one-cycle pulse |

## Verification
The bench measures the busy phase to the exact cycle. A counter that is off by one shows up as a low-time of BUSY_CYC±1. It also sets lock bits with addresses that carry extra bits outside the block field, so a mis-sliced block index locks the wrong block. Every fault cause is checked against its exact status byte: voltage, master without the qualifier, master-protected set and clear, invalid confirm, and suspended setup. A design that mixes up bits 4 and 5, or lets the protection check override the voltage check, therefore fails on a specific value. Command bytes written during the busy phase, and a confirm written after a refused setup, must leave the locks and the ready flag untouched.

// File: rtl/lockbit_pkg.sv
package lockbit_pkg;

   localparam logic [7:0] OPC_SETUP  = 8'h60;
   localparam logic [7:0] OPC_CF_BLK = 8'h01;
   localparam logic [7:0] OPC_CF_MST = 8'hF1;
   localparam logic [7:0] OPC_CF_CLR = 8'hD0;
   localparam logic [7:0] OPC_CLR_SR = 8'h50;
   localparam logic [7:0] OPC_RD_ARR = 8'hFF;

   typedef enum logic [1:0] {ST_READY, ST_SETUP, ST_BUSY} seq_st_t;
   typedef enum logic [1:0] {OP_NONE, OP_SET_BLK, OP_SET_MST, OP_CLR_ALL} lock_op_t;

   // error flags, mapped to status bits 5,4,3,1
   typedef struct packed {
      logic erase;
      logic prog;
      logic volt;
      logic prot;
   } sr_err_t;

   localparam sr_err_t ERR_NONE = '{erase: 1'b0, prog: 1'b0, volt: 1'b0, prot: 1'b0};
   localparam sr_err_t ERR_SEQ  = '{erase: 1'b1, prog: 1'b1, volt: 1'b0, prot: 1'b0};

   function automatic sr_err_t eval_fault(lock_op_t op, logic vpp, logic hv, logic mst);
      sr_err_t e;
      e = ERR_NONE;
      if (!vpp) begin
         e.volt  = 1'b1;
         e.erase = (op == OP_CLR_ALL);
         e.prog  = (op != OP_CLR_ALL);
      end else if (!hv && (op == OP_SET_MST || mst)) begin
         e.prot  = 1'b1;
         e.erase = (op == OP_CLR_ALL);
         e.prog  = (op != OP_CLR_ALL);
      end
      return e;
   endfunction

endpackage

// File: rtl/lockbit_seq.sv
module lockbit_seq
   import lockbit_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int BLK_LSB   = 12,
   parameter int BLK_IDX_W = 3,
   parameter int BUSY_CYC  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [7:0]           wr_cmd,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 hv_qual,
   input  logic                 vpp_ok,
   input  logic                 suspended,
   input  logic                 master_lock,
   output logic                 busy,
   output logic                 idle,
   output sr_err_t              err_set,
   output logic                 clr_sr,
   output lock_op_t             apply_op,
   output logic [BLK_IDX_W-1:0] apply_blk,
   output logic                 rd_status_mode
);

   localparam int CNT_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC - 1);

   seq_st_t              state;
   logic [CNT_W-1:0]     cnt;
   lock_op_t             pend_op;
   sr_err_t              pend_err;
   logic [BLK_IDX_W-1:0] pend_blk;
   lock_op_t             conf_op;
   logic                 cmd_in;
   logic                 finish;

   assign cmd_in = wr_en && (state != ST_BUSY);
   assign finish = (state == ST_BUSY) && (cnt == '0);
   assign busy   = (state == ST_BUSY);
   assign idle   = (state == ST_READY);

   always_comb begin
      unique case (wr_cmd)
         OPC_CF_BLK: conf_op = OP_SET_BLK;
         OPC_CF_MST: conf_op = OP_SET_MST;
         OPC_CF_CLR: conf_op = OP_CLR_ALL;
         default:    conf_op = OP_NONE;
      endcase
   end

   always_comb begin
      err_set   = ERR_NONE;
      apply_op  = OP_NONE;
      apply_blk = pend_blk;
      clr_sr    = 1'b0;
      if (finish) begin
         err_set  = pend_err;
         apply_op = (pend_err == ERR_NONE) ? pend_op : OP_NONE;
      end else if (cmd_in && state == ST_READY) begin
         if (wr_cmd == OPC_SETUP && suspended) err_set = ERR_SEQ;
         clr_sr = (wr_cmd == OPC_CLR_SR);
      end else if (cmd_in && state == ST_SETUP) begin
         if (conf_op == OP_NONE || suspended) err_set = ERR_SEQ;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state          <= ST_READY;
         cnt            <= '0;
         pend_op        <= OP_NONE;
         pend_err       <= ERR_NONE;
         pend_blk       <= '0;
         rd_status_mode <= 1'b0;
      end else begin
         unique case (state)
            ST_READY: if (cmd_in) begin
               if (wr_cmd == OPC_SETUP && !suspended) begin
                  state          <= ST_SETUP;
                  rd_status_mode <= 1'b1;
               end else if (wr_cmd == OPC_RD_ARR) begin
                  rd_status_mode <= 1'b0;
               end
            end
            ST_SETUP: if (cmd_in) begin
               if (conf_op != OP_NONE && !suspended) begin
                  state    <= ST_BUSY;
                  cnt      <= CNT_LOAD;
                  pend_op  <= conf_op;
                  pend_blk <= bus_addr[BLK_LSB +: BLK_IDX_W];
                  pend_err <= eval_fault(conf_op, vpp_ok, hv_qual, master_lock);
               end else begin
                  state <= ST_READY;
               end
            end
            ST_BUSY: begin
               if (cnt == '0) state <= ST_READY;
               else           cnt   <= cnt - 1'b1;
            end
            default: state <= ST_READY;
         endcase
      end
   end

endmodule

// File: rtl/lockbit_store.sv
module lockbit_store
   import lockbit_pkg::*;
#(
   parameter int NUM_BLK   = 8,
   parameter int BLK_IDX_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  lock_op_t             apply_op,
   input  logic [BLK_IDX_W-1:0] apply_blk,
   output logic [NUM_BLK-1:0]   blk_locks,
   output logic                 master_lock
);

   for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
      logic hit;
      assign hit = (apply_op == OP_SET_BLK) && (apply_blk == BLK_IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      blk_locks[i] <= 1'b0;
         else if (apply_op == OP_CLR_ALL) blk_locks[i] <= 1'b0;
         else if (hit)                    blk_locks[i] <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      master_lock <= 1'b0;
      else if (apply_op == OP_SET_MST) master_lock <= 1'b1;
   end

endmodule

// File: rtl/lockbit_pe_gate.sv
module lockbit_pe_gate
   import lockbit_pkg::*;
#(
   parameter int NUM_BLK   = 8,
   parameter int BLK_IDX_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pe_req,
   input  logic                 pe_erase,
   input  logic [BLK_IDX_W-1:0] pe_blk,
   input  logic                 idle,
   input  logic [NUM_BLK-1:0]   blk_locks,
   output sr_err_t              err_set,
   output logic                 pe_go
);

   logic take;
   logic locked;

   assign take   = pe_req && idle;
   assign locked = blk_locks[pe_blk];

   always_comb begin
      err_set       = ERR_NONE;
      err_set.prot  = take && locked;
      err_set.prog  = take && locked && !pe_erase;
      err_set.erase = take && locked && pe_erase;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pe_go <= 1'b0;
      else        pe_go <= take && !locked;
   end

endmodule

// File: rtl/lockbit_status.sv
module lockbit_status
   import lockbit_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    busy,
   input  logic    clr_sr,
   input  sr_err_t err_seq,
   input  sr_err_t err_pe,
   output logic [7:0] status
);

   sr_err_t err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= ERR_NONE;
      else        err_q <= (clr_sr ? ERR_NONE : err_q) | err_seq | err_pe;
   end

   assign status = {!busy, 1'b0, err_q.erase, err_q.prog, err_q.volt, 1'b0, err_q.prot, 1'b0};

endmodule

// File: rtl/lockbit_cmd_ctrl.sv
module lockbit_cmd_ctrl
   import lockbit_pkg::*;
#(
   parameter int NUM_BLK  = 8,
   parameter int ADDR_W   = 16,
   parameter int BLK_LSB  = 12,
   parameter int BUSY_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        wr_cmd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              pe_req,
   input  logic              pe_erase,
   input  logic              hv_qual,
   input  logic              vpp_ok,
   input  logic              suspended,
   output logic              ready,
   output logic [7:0]        status,
   output logic              rd_status_mode,
   output logic [NUM_BLK-1:0] blk_locks,
   output logic              master_lock,
   output logic              pe_go
);

   localparam int BLK_IDX_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;

   if (NUM_BLK < 2 || (1 << BLK_IDX_W) != NUM_BLK) begin : g_bad_nblk
      $error("NUM_BLK must be a power of two, at least 2");
   end
   if (BLK_LSB + BLK_IDX_W > ADDR_W) begin : g_bad_field
      $error("block index field does not fit in ADDR_W");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("BUSY_CYC must be at least 1");
   end

   logic                 busy;
   logic                 idle;
   logic                 clr_sr;
   sr_err_t              err_seq;
   sr_err_t              err_pe;
   lock_op_t             apply_op;
   logic [BLK_IDX_W-1:0] apply_blk;

   lockbit_seq #(
      .ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .BLK_IDX_W(BLK_IDX_W), .BUSY_CYC(BUSY_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .bus_addr(bus_addr),
      .hv_qual(hv_qual), .vpp_ok(vpp_ok), .suspended(suspended),
      .master_lock(master_lock), .busy(busy), .idle(idle), .err_set(err_seq),
      .clr_sr(clr_sr), .apply_op(apply_op), .apply_blk(apply_blk),
      .rd_status_mode(rd_status_mode)
   );

   lockbit_store #(.NUM_BLK(NUM_BLK), .BLK_IDX_W(BLK_IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .apply_op(apply_op), .apply_blk(apply_blk),
      .blk_locks(blk_locks), .master_lock(master_lock)
   );

   lockbit_pe_gate #(.NUM_BLK(NUM_BLK), .BLK_IDX_W(BLK_IDX_W)) u_pe (
      .clk(clk), .rst_n(rst_n), .pe_req(pe_req), .pe_erase(pe_erase),
      .pe_blk(bus_addr[BLK_LSB +: BLK_IDX_W]), .idle(idle), .blk_locks(blk_locks),
      .err_set(err_pe), .pe_go(pe_go)
   );

   lockbit_status u_stat (
      .clk(clk), .rst_n(rst_n), .busy(busy), .clr_sr(clr_sr),
      .err_seq(err_seq), .err_pe(err_pe), .status(status)
   );

   assign ready = !busy;

endmodule

// File: rtl/lockbit_cmd_ctrl_chk.sv
module lockbit_cmd_ctrl_chk #(
   parameter int NUM_BLK  = 8,
   parameter int BUSY_CYC = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [7:0]         wr_cmd,
   input logic               pe_req,
   input logic               ready,
   input logic [7:0]         status,
   input logic [NUM_BLK-1:0] blk_locks,
   input logic               master_lock,
   input logic               pe_go
);

   localparam int LW = $clog2(BUSY_CYC + 1) + 1;
   logic [LW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      low_cnt <= '0;
      else if (!ready) low_cnt <= low_cnt + 1'b1;
      else             low_cnt <= '0;
   end

   p_busy_short_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && low_cnt < LW'(BUSY_CYC - 1)) |=> !ready);
   p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && low_cnt == LW'(BUSY_CYC - 1)) |=> ready);
   p_lock_change_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(blk_locks) |-> $rose(ready));
   p_one_new_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(blk_locks & ~$past(blk_locks)) <= 1);
   p_clear_is_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(blk_locks) & ~blk_locks)) |-> (blk_locks == '0));
   p_master_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      master_lock |=> master_lock);
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(status[4]) || $fell(status[5]) || $fell(status[3]) || $fell(status[1]))
      |-> ($past(wr_en) && $past(wr_cmd) == 8'h50));
   p_pe_go_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pe_go |-> ($past(pe_req) && $past(ready)));
   p_sr7_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
      status[7] == ready);

endmodule

bind lockbit_cmd_ctrl lockbit_cmd_ctrl_chk #(.NUM_BLK(NUM_BLK), .BUSY_CYC(BUSY_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .pe_req(pe_req),
   .ready(ready), .status(status), .blk_locks(blk_locks),
   .master_lock(master_lock), .pe_go(pe_go)
);

// File: tb/lockbit_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module lockbit_cmd_ctrl_tb;

   localparam int NUM_BLK  = 8;
   localparam int ADDR_W   = 16;
   localparam int BUSY_CYC = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [7:0] wr_cmd = 8'h00;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic pe_req = 1'b0, pe_erase = 1'b0;
   logic hv_qual = 1'b0, vpp_ok = 1'b1, suspended = 1'b0;
   logic ready, rd_status_mode, master_lock, pe_go;
   logic [7:0] status;
   logic [NUM_BLK-1:0] blk_locks;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lockbit_cmd_ctrl #(.NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W), .BLK_LSB(12), .BUSY_CYC(BUSY_CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .bus_addr(bus_addr),
      .pe_req(pe_req), .pe_erase(pe_erase), .hv_qual(hv_qual), .vpp_ok(vpp_ok),
      .suspended(suspended), .ready(ready), .status(status),
      .rd_status_mode(rd_status_mode), .blk_locks(blk_locks),
      .master_lock(master_lock), .pe_go(pe_go)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] c, input logic [15:0] a);
      @(negedge clk);
      wr_en = 1'b1; wr_cmd = c; bus_addr = a;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic lock_seq(input logic [7:0] conf, input logic [15:0] a);
      wr(8'h60, 16'h0000);
      wr(conf, a);
   endtask

   task automatic wait_busy(input string tag);
      int n = 0;
      while (!ready && n < 100) begin
         if (status[7] !== ready) chk("R12 sr7 mirrors ready", status[7], ready);
         n++;
         @(negedge clk);
      end
      chk(tag, n, BUSY_CYC);
   endtask

   task automatic clr_status();
      wr(8'h50, 16'h0000);
   endtask

   task automatic t_reset();
      chk("R1 status", status, 8'h80);
      chk("R1 locks", blk_locks, 0);
      chk("R1 master", master_lock, 0);
      chk("R1 mode", rd_status_mode, 0);
      chk("R1 ready", ready, 1);
   endtask

   task automatic t_set_block();
      lock_seq(8'h01, 16'h3ABC);
      chk("R2 ready low after confirm", ready, 0);
      chk("R12 sr7 low", status[7], 0);
      wait_busy("R2 busy length");
      chk("R2 block 3 set", blk_locks, 8'h08);
      chk("R2 status", status, 8'h80);
      chk("R10 status mode on", rd_status_mode, 1);
      lock_seq(8'h01, 16'h7000);
      wait_busy("R2 busy length blk7");
      lock_seq(8'h01, 16'h9FFF);   // bit15 outside field, field=1
      wait_busy("R2 busy length blk1");
      chk("R2 field position", blk_locks, 8'h8A);
   endtask

   task automatic t_mode();
      wr(8'hFF, 16'h0000);
      chk("R10 status mode off", rd_status_mode, 0);
   endtask

   task automatic t_invalid();
      lock_seq(8'h20, 16'h2000);
      chk("R6 flags", status, 8'hB0);
      chk("R6 no busy", ready, 1);
      chk("R6 locks", blk_locks, 8'h8A);
      wr(8'hFF, 16'h0000);
      chk("R9 sticky across other cmd", status, 8'hB0);
      clr_status();
      chk("R9 cleared by 0x50", status, 8'h80);
   endtask

   task automatic t_vpp();
      vpp_ok = 1'b0;
      lock_seq(8'hD0, 16'h0000);
      wait_busy("R7 busy clr");
      chk("R7 clear volt flags", status, 8'hA8);
      chk("R7 locks kept", blk_locks, 8'h8A);
      clr_status();
      lock_seq(8'h01, 16'h2000);
      wait_busy("R7 busy set");
      chk("R7 set volt flags", status, 8'h98);
      chk("R7 locks kept set", blk_locks, 8'h8A);
      clr_status();
      vpp_ok = 1'b1;
   endtask

   task automatic t_clear();
      lock_seq(8'hD0, 16'h5555);
      wait_busy("R3 busy");
      chk("R3 all cleared", blk_locks, 0);
      chk("R3 status", status, 8'h80);
   endtask

   task automatic t_busy_ignore();
      lock_seq(8'h01, 16'h2000);
      wr(8'h60, 16'h0000);
      wr(8'hD0, 16'h0000);
      while (!ready) @(negedge clk);
      @(negedge clk);
      chk("R8 busy writes ignored ready", ready, 1);
      chk("R8 busy writes ignored locks", blk_locks, 8'h04);
      chk("R8 status", status, 8'h80);
   endtask

   task automatic t_suspend();
      suspended = 1'b1;
      wr(8'h60, 16'h0000);
      chk("R8 suspended setup flags", status, 8'hB0);
      suspended = 1'b0;
      wr(8'h01, 16'h5000);
      chk("R8 no sequence after refused setup", ready, 1);
      chk("R8 locks after refused setup", blk_locks, 8'h04);
      clr_status();
      wr(8'h60, 16'h0000);
      suspended = 1'b1;
      wr(8'h01, 16'h5000);
      chk("R8 suspended confirm", status, 8'hB0);
      chk("R8 suspended confirm ready", ready, 1);
      chk("R8 suspended confirm locks", blk_locks, 8'h04);
      suspended = 1'b0;
      clr_status();
   endtask

   task automatic t_master();
      hv_qual = 1'b0;
      lock_seq(8'hF1, 16'h1234);
      wait_busy("R4 busy no hv");
      chk("R4 no hv flags", status, 8'h92);
      chk("R4 master unchanged", master_lock, 0);
      clr_status();
      hv_qual = 1'b1;
      lock_seq(8'hF1, 16'hABCD);
      wait_busy("R4 busy hv");
      chk("R4 master set", master_lock, 1);
      chk("R4 status", status, 8'h80);
      hv_qual = 1'b0;
   endtask

   task automatic t_master_protect();
      lock_seq(8'h01, 16'h5000);
      wait_busy("R5 busy set");
      chk("R5 set refused flags", status, 8'h92);
      chk("R5 set refused locks", blk_locks, 8'h04);
      clr_status();
      lock_seq(8'hD0, 16'h0000);
      wait_busy("R5 busy clr");
      chk("R5 clear refused flags", status, 8'hA2);
      chk("R5 clear refused locks", blk_locks, 8'h04);
      clr_status();
      hv_qual = 1'b1;
      lock_seq(8'h01, 16'h5000);
      wait_busy("R5 busy set hv");
      chk("R5 set with hv", blk_locks, 8'h24);
      lock_seq(8'hD0, 16'h0000);
      wait_busy("R5 busy clr hv");
      chk("R5 clear with hv", blk_locks, 0);
      lock_seq(8'h01, 16'h6000);
      wait_busy("R5 busy set6");
      chk("R5 block 6", blk_locks, 8'h40);
      chk("R4 master never clears", master_lock, 1);
      hv_qual = 1'b0;
   endtask

   task automatic pe(input logic er, input logic [15:0] a);
      @(negedge clk);
      pe_req = 1'b1; pe_erase = er; bus_addr = a;
      @(negedge clk);
      pe_req = 1'b0;
   endtask

   task automatic t_pe();
      pe(1'b0, 16'h6010);
      chk("R11 program locked flags", status, 8'h92);
      chk("R11 program locked no go", pe_go, 0);
      clr_status();
      pe(1'b1, 16'h6000);
      chk("R11 erase locked flags", status, 8'hA2);
      chk("R11 erase locked no go", pe_go, 0);
      clr_status();
      pe(1'b0, 16'h1000);
      chk("R11 unlocked go", pe_go, 1);
      chk("R11 unlocked status", status, 8'h80);
      @(negedge clk);
      chk("R11 go one cycle", pe_go, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_block();
      t_mode();
      t_invalid();
      t_vpp();
      t_clear();
      t_busy_ignore();
      t_suspend();
      t_master();
      t_master_protect();
      t_pe();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog got=hung exp=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule